// File: doc/BRIEF.md
# Periodic Auto-Reload Wakeup Timer

A down-counter advanced by a once-per-second tick strobe that raises a sticky wakeup flag each time its count runs out, then reloads itself from a programmable 17-bit reload value with no software action. Software arms it through a level enable. That enable crosses into the counter through two reference-clock flops and then two tick-clocked stages. Counting starts on the tick after that, so the first flag lands a fixed number of ticks after the enable is seen.

A synchronization-done flag tells software that the enable has reached the counter. A write-allowed flag tells software that the timer is fully idle, and only then may the reload value be changed. The interrupt output is the wakeup flag qualified by an interrupt enable. The tick is a one-cycle strobe in the reference clock domain.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, wake_flag_o, irq_o and sync_done_o are 0, and wr_allow_o is 1.
- R2: If enable_i is set at least two clock cycles before a tick, the first wake_flag_o sets on the edge of tick number reload+4, counting from the first tick after that point. These ticks are two tick-stage ticks, one load tick and reload+1 counting ticks.
- R3: While the timer is running, wake_flag_o sets again every reload+1 ticks, and it sets only on an edge where tick_i is high. A reload value of 0 gives a flag on every tick.
- R4: sync_done_o sets on the load tick, the third tick after enable_i is synchronized. It is cleared by sync_clr_i, by init_i, or when counting stops, and it is never 1 while the timer is stopped.
- R5: irq_o is 1 exactly when wake_flag_o and irq_en_i are both 1.
- R6: wake_flag_o stays set until flag_clr_i is pulsed, and it reads 0 on the cycle after the clear.
- R7: wr_allow_o drops to 0 within two clock cycles of enable_i rising. A pulse on reload_we_i is ignored while wr_allow_o is 0, so the running period is unchanged.
- R8: When enable_i is cleared, counting stops on the third tick after the enable has synchronized low, and sync_done_o clears at that point. wr_allow_o returns to 1 one clock later, and no further flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle tick strobe (nominally 1 Hz) |
| enable_i | input | 1 | Timer enable level |
| irq_en_i | input | 1 | Interrupt enable |
| reload_i | input | 17 | Reload value |
| reload_we_i | input | 1 | Reload write strobe, taken only while wr_allow_o is 1 |
| flag_clr_i | input | 1 | Clears the wakeup flag |
| sync_clr_i | input | 1 | Clears sync_done_o |
| init_i | input | 1 | Initialization mode, clears sync_done_o |
| wake_flag_o | output | 1 | Sticky wakeup flag |
| irq_o | output | 1 | Wakeup interrupt |
| sync_done_o | output | 1 | Enable has propagated to the counter |
| wr_allow_o | output | 1 | Reload value may be written |

## Verification
Flag and sync-done results are registered on the clock edge that samples the tick. The bench therefore drives each tick for one cycle from a falling edge and reads those outputs on the next falling edge. wr_allow_o follows the idle state one register later, so after the stop tick it is read one extra cycle on. The sweep counts ticks from the arming point and predicts every flag arithmetically, from the load at tick 3 and the period of reload+1. irq_o is checked combinationally against the flag in the same sample.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned DEF_CNT_W       = 17;
  localparam int unsigned DEF_CLK_STAGES  = 2;
  localparam int unsigned DEF_TICK_STAGES = 2;

  typedef struct packed {
    logic start;
    logic stop;
    logic expire;
  } wkt_evt_t;
endpackage

// File: rtl/wkt_sync.sv
module wkt_sync #(
  parameter int unsigned CLK_STAGES  = wkt_pkg::DEF_CLK_STAGES,
  parameter int unsigned TICK_STAGES = wkt_pkg::DEF_TICK_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  output logic run_o,
  output logic start_o,
  output logic stop_o,
  output logic idle_o
);
  logic [CLK_STAGES-1:0]  cs_q;
  logic [TICK_STAGES-1:0] ts_q;
  logic                   run_q;

  for (genvar i = 0; i < CLK_STAGES; i++) begin : g_clk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_q[i] <= 1'b0;
      else         cs_q[i] <= (i == 0) ? en_i : cs_q[(i == 0) ? 0 : i-1];
    end
  end

  for (genvar j = 0; j < TICK_STAGES; j++) begin : g_tick
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ts_q[j] <= 1'b0;
      else if (tick_i) ts_q[j] <= (j == 0) ? cs_q[CLK_STAGES-1] : ts_q[(j == 0) ? 0 : j-1];
    end
  end

  assign start_o = tick_i &  ts_q[TICK_STAGES-1] & ~run_q;
  assign stop_o  = tick_i & ~ts_q[TICK_STAGES-1] &  run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (start_o) run_q <= 1'b1;
    else if (stop_o)  run_q <= 1'b0;
  end

  assign run_o  = run_q;
  assign idle_o = ~(|cs_q) & ~(|ts_q) & ~run_q;
endmodule

// File: rtl/wkt_count.sv
module wkt_count #(
  parameter int unsigned CNT_W = wkt_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             zero;

  assign zero     = (cnt_q == '0);
  assign expire_o = tick_i & run_i & zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= reload_i;
    else if (tick_i && run_i) cnt_q <= zero ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wkt_status.sv
module wkt_status (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  wkt_pkg::wkt_evt_t  evt_i,
  input  logic               idle_i,
  input  logic               flag_clr_i,
  input  logic               sync_clr_i,
  input  logic               init_i,
  output logic               flag_o,
  output logic               sync_done_o,
  output logic               wr_allow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           flag_o <= 1'b0;
    else if (evt_i.expire) flag_o <= 1'b1;
    else if (flag_clr_i)   flag_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  sync_done_o <= 1'b0;
    else if (evt_i.start)                         sync_done_o <= 1'b1;
    else if (evt_i.stop || sync_clr_i || init_i)  sync_done_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_allow_o <= 1'b1;
    else         wr_allow_o <= idle_i;
  end
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer #(
  parameter int unsigned CNT_W       = wkt_pkg::DEF_CNT_W,
  parameter int unsigned CLK_STAGES  = wkt_pkg::DEF_CLK_STAGES,
  parameter int unsigned TICK_STAGES = wkt_pkg::DEF_TICK_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             reload_we_i,
  input  logic             flag_clr_i,
  input  logic             sync_clr_i,
  input  logic             init_i,
  output logic             wake_flag_o,
  output logic             irq_o,
  output logic             sync_done_o,
  output logic             wr_allow_o
);
  wkt_pkg::wkt_evt_t evt;
  logic              run;
  logic              idle;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        reload_q <= '0;
    else if (reload_we_i && wr_allow_o) reload_q <= reload_i;
  end

  wkt_sync #(.CLK_STAGES(CLK_STAGES), .TICK_STAGES(TICK_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .en_i    (enable_i),
    .run_o   (run),
    .start_o (evt.start),
    .stop_o  (evt.stop),
    .idle_o  (idle)
  );

  wkt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run),
    .start_i  (evt.start),
    .reload_i (reload_q),
    .cnt_o    (cnt),
    .expire_o (evt.expire)
  );

  wkt_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .idle_i      (idle),
    .flag_clr_i  (flag_clr_i),
    .sync_clr_i  (sync_clr_i),
    .init_i      (init_i),
    .flag_o      (wake_flag_o),
    .sync_done_o (sync_done_o),
    .wr_allow_o  (wr_allow_o)
  );

  assign irq_o = wake_flag_o & irq_en_i;
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker #(
  parameter int unsigned CNT_W = wkt_pkg::DEF_CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             flag_clr_i,
  input logic             wake_flag_o,
  input logic             irq_o,
  input logic             sync_done_o,
  input logic             wr_allow_o,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i
);
  a_r3_flag_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_flag_o) |-> $past(tick_i));

  a_r3_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i <= reload_i));

  a_r4_sync_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |-> run_i);

  a_r5_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_flag_o);

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_flag_o && !flag_clr_i) |=> wake_flag_o);

  a_r7_reload_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_allow_o |=> $stable(reload_i));

  a_r8_allow_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_allow_o |-> !run_i);
endmodule

bind wakeup_timer wkt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .flag_clr_i  (flag_clr_i),
  .wake_flag_o (wake_flag_o),
  .irq_o       (irq_o),
  .sync_done_o (sync_done_o),
  .wr_allow_o  (wr_allow_o),
  .run_i       (run),
  .cnt_i       (cnt),
  .reload_i    (reload_q)
);

// File: tb/wakeup_timer_bench.sv
module wakeup_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, en = 1'b0, irq_en = 1'b0;
  logic [16:0] reload = '0;
  logic        we = 1'b0, fclr = 1'b0, sclr = 1'b0, init = 1'b0;
  logic        flag, irq, sdone, wallow;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wakeup_timer u_wakeup_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .enable_i(en), .irq_en_i(irq_en),
    .reload_i(reload), .reload_we_i(we), .flag_clr_i(fclr), .sync_clr_i(sclr),
    .init_i(init), .wake_flag_o(flag), .irq_o(irq), .sync_done_o(sdone),
    .wr_allow_o(wallow)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) fclr = 1'b1;
    @(negedge clk) fclr = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R1 flag", flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sync_done", sdone, 1'b0);
    chk("R1 wr_allow", wallow, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    chk("R1 wr_allow after release", wallow, 1'b1);

    for (int w = 0; w <= 6; w++) begin
      logic sd_exp;
      int   last;
      // reload write while idle
      @(negedge clk) begin reload = 17'(w); we = 1'b1; end
      @(negedge clk) we = 1'b0;
      irq_en = w[0];
      @(negedge clk) en = 1'b1;
      cyc(2);
      chk("R7 wr_allow low after enable", wallow, 1'b0);
      // ignored write
      @(negedge clk) begin reload = 17'(w + 3); we = 1'b1; end
      @(negedge clk) we = 1'b0;
      sd_exp = 1'b0;
      last = (w + 4) + 3 * (w + 1);
      for (int k = 1; k <= last; k++) begin
        logic exp;
        do_tick();
        exp = (k >= w + 4) && (((k - (w + 4)) % (w + 1)) == 0);
        chk((k < w + 5) ? "R2 first flag" : "R3 periodic flag", flag, exp);
        chk("R5 irq gating", irq, exp & irq_en);
        if (k == 3) sd_exp = 1'b1;
        chk("R4 sync_done", sdone, sd_exp);
        if (k == 5 && w == 1) begin
          @(negedge clk) sclr = 1'b1;
          @(negedge clk) sclr = 1'b0;
          sd_exp = 1'b0;
          chk("R4 sync_clr clears", sdone, 1'b0);
        end
        if (k == 5 && w == 3) begin
          @(negedge clk) init = 1'b1;
          @(negedge clk) init = 1'b0;
          sd_exp = 1'b0;
          chk("R4 init clears", sdone, 1'b0);
        end
        if (exp) begin
          cyc(2);
          chk("R6 flag held without clear", flag, 1'b1);
          pulse_clr();
          chk("R6 flag cleared", flag, 1'b0);
        end
      end
      // stop sequence
      @(negedge clk) en = 1'b0;
      cyc(3);
      for (int k = 1; k <= 3; k++) begin
        do_tick();
        pulse_clr();
      end
      chk("R8 sync_done cleared on stop", sdone, 1'b0);
      chk("R8 wr_allow back", wallow, 1'b1);
      for (int k = 1; k <= w + 3; k++) begin
        do_tick();
        chk("R8 no flag after stop", flag, 1'b0);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule